// File: doc/BRIEF.md
# Serial Transmitter with Transmit Queue and CTS Gating

This block turns bytes from a host into asynchronous serial frames. Bytes are written into a queue of up to 16 entries. The queue can also be reduced to a single holding register. Each frame has a start bit at 0, then 5 to 8 data bits with the least significant bit first, then an optional even or odd parity bit, and finally a stop period of 1, 1.5 or 2 bits at level 1.

All timing comes from `tick16`. This is a one-cycle enable pulse at 16 times the baud rate, made by a divisor outside the block. A bit lasts 16 ticks. The stop period can be 16, 24 or 32 ticks.

Character settings are sampled when a frame starts, so they stay fixed for the whole frame. When automatic flow control is on, a new frame starts only while `cts` is high. A frame already on the line always finishes. A break request pulls the line low for as long as it is held. Status outputs show room in the queue (`txrdy`), a fully drained transmitter (`tx_empty_irq`) and a sticky overflow (`ovf_flag`).

Top module: `sertx_fc`

## Requirements
- R1: While reset is held and after it is released, `txd`=1, `txrdy`=1, `tx_empty_irq`=1 and `ovf_flag`=0.
- R2: A frame is one start bit at 0, then `cfg_len`+5 data bits sent LSB first (`cfg_len` 0,1,2,3 gives 5,6,7,8 bits), then the parity bit if enabled, then the stop period at 1.
- R3: When `cfg_par_en`=1, a parity bit follows the data. It is the XOR of only the configured data bits, inverted when `cfg_par_odd`=1.
- R4: `cfg_stop`=00 gives a 16-tick stop period, 01 gives 24 ticks and 1x gives 32 ticks. Frames queued back to back start exactly one frame length apart.
- R5: Every start, data and parity bit lasts 16 ticks. `txd` changes only in the cycle after a tick, unless the break request changes.
- R6: With `cfg_fifo_en`=1 the queue holds 16 bytes and sends them in write order. `txrdy` is 1 exactly while fewer than 16 are held.
- R7: With `cfg_fifo_en`=0 the queue holds one byte. `txrdy` goes to 0 after a write and returns to 1 when the byte moves into the shifter.
- R8: A write while `txrdy`=0 is dropped and sets `ovf_flag`, which stays set until reset.
- R9: With `cfg_auto_cts`=1, no frame starts while `cts`=0. With `cfg_auto_cts`=0, `cts` has no effect.
- R10: If `cts` falls during a frame, that frame still completes intact, and the next one waits for `cts`.
- R11: While `cfg_break`=1, `txd` is 0.
- R12: `tx_empty_irq` is 1 only when the queue is empty and no frame is on the line, including its stop period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | One-cycle enable at 16x baud |
| cfg_len | input | 2 | Data bits minus 5 |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_stop | input | 2 | Stop length: 00=1, 01=1.5, 1x=2 bits |
| cfg_break | input | 1 | Force line low |
| cfg_fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| cfg_auto_cts | input | 1 | Gate frame starts with cts |
| cts | input | 1 | Clear to send, active high |
| wr_en | input | 1 | Write strobe for wr_data |
| wr_data | input | 8 | Byte to send |
| txd | output | 1 | Serial output, idle at 1 |
| txrdy | output | 1 | Queue can accept a byte |
| tx_empty_irq | output | 1 | Queue and shifter both empty |
| ovf_flag | output | 1 | Sticky dropped-write flag |

## Verification
The framing is swept over all 36 combinations of length, parity mode and stop length. For each combination two frames are sent back to back, and their bytes are chosen so that the data beyond the configured length differs from the data inside it. This separates an error in the length or parity mask from a shift-order error. The time between the two start edges is checked against a value computed from the settings, which catches any miscount of the stop period or of the bit length.

A queue of 16 distinct values, held back by `cts`, shows ordering, the full boundary and the dropped 17th write. A single-byte run shows the holding-register mode. A `cts` drop in the middle of a frame shows that frames finish at their boundary before the line pauses.

// File: rtl/sertx_fc.sv
module sertx_fc #(
  parameter int DEPTH = 16,
  parameter int OSR   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_odd,
  input  logic [1:0] cfg_stop,
  input  logic       cfg_break,
  input  logic       cfg_fifo_en,
  input  logic       cfg_auto_cts,
  input  logic       cts,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       txrdy,
  output logic       tx_empty_irq,
  output logic       ovf_flag
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(2 * OSR);
  localparam int HALF = OSR / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  st_t           st;
  logic [CW-1:0] tcnt;
  logic [7:0]    sh;
  logic [2:0]    bitn;
  logic [1:0]    l_len, l_stop;
  logic          l_par, par_bit, line;

  logic full, push, launch, bit_end, stop_end, data_last;
  logic [7:0] head, mask;
  int stop_lim;

  assign full   = cfg_fifo_en ? (cnt >= (AW+1)'(DEPTH)) : (cnt != '0);
  assign push   = wr_en && !full;
  assign head   = mem[rp];
  assign mask   = 8'hFF >> (2'd3 - cfg_len);

  assign bit_end   = tcnt == CW'(OSR - 1);
  assign stop_lim  = (l_stop == 2'b00) ? OSR : (l_stop == 2'b01) ? OSR + HALF : 2 * OSR;
  assign stop_end  = tcnt == CW'(stop_lim - 1);
  assign data_last = bitn == (3'(l_len) + 3'd4);

  assign launch = tick16 && (cnt != '0) && (!cfg_auto_cts || cts) &&
                  (st == S_IDLE || (st == S_STOP && stop_end));

  assign txd          = line & ~cfg_break;
  assign txrdy        = !full;
  assign tx_empty_irq = (cnt == '0) && (st == S_IDLE);

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      ovf_flag <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (launch) rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(push) - (AW+1)'(launch);
      if (wr_en && full) ovf_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tcnt <= '0;
      sh <= '0;
      bitn <= '0;
      l_len <= '0;
      l_stop <= '0;
      l_par <= 1'b0;
      par_bit <= 1'b0;
      line <= 1'b1;
    end else if (tick16) begin
      if (launch) begin
        st <= S_START;
        tcnt <= '0;
        line <= 1'b0;
        sh <= head;
        bitn <= '0;
        l_len <= cfg_len;
        l_stop <= cfg_stop;
        l_par <= cfg_par_en;
        par_bit <= ^(head & mask) ^ cfg_par_odd;
      end else begin
        case (st)
          S_START: begin
            if (bit_end) begin
              st <= S_DATA;
              tcnt <= '0;
              line <= sh[0];
            end else tcnt <= tcnt + 1'b1;
          end
          S_DATA: begin
            if (bit_end) begin
              tcnt <= '0;
              if (data_last) begin
                st <= l_par ? S_PAR : S_STOP;
                line <= l_par ? par_bit : 1'b1;
              end else begin
                sh <= sh >> 1;
                line <= sh[1];
                bitn <= bitn + 1'b1;
              end
            end else tcnt <= tcnt + 1'b1;
          end
          S_PAR: begin
            if (bit_end) begin
              st <= S_STOP;
              tcnt <= '0;
              line <= 1'b1;
            end else tcnt <= tcnt + 1'b1;
          end
          S_STOP: begin
            if (stop_end) begin
              st <= S_IDLE;
              tcnt <= '0;
            end else tcnt <= tcnt + 1'b1;
          end
          default: line <= 1'b1;
        endcase
      end
    end
  end

  logic at_start;
  assign at_start = (st == S_START);
endmodule

// File: rtl/sertx_fc_chk.sv
module sertx_fc_chk (
  input logic clk,
  input logic rst_n,
  input logic tick16,
  input logic cfg_break,
  input logic cfg_auto_cts,
  input logic cts,
  input logic txd,
  input logic tx_empty_irq,
  input logic ovf_flag,
  input logic at_start
);
  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_break |-> !txd); // R11
  AST_EMPTY_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty_irq && !cfg_break) |-> txd); // R12
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag); // R8
  AST_CTS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(at_start) |-> $past(!cfg_auto_cts || cts)); // R9
  AST_TICK_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!tick16) && $stable(cfg_break)) |-> $stable(txd)); // R5
endmodule

bind sertx_fc sertx_fc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .cfg_break(cfg_break),
  .cfg_auto_cts(cfg_auto_cts), .cts(cts), .txd(txd),
  .tx_empty_irq(tx_empty_irq), .ovf_flag(ovf_flag), .at_start(at_start)
);

// File: tb/test_sertx_fc.sv
module test_sertx_fc;
  logic clk = 0, rst_n = 0, tick16 = 0;
  logic [1:0] cfg_len = 2'd3, cfg_stop = 2'd0;
  logic cfg_par_en = 0, cfg_par_odd = 0, cfg_break = 0, cfg_fifo_en = 1;
  logic cfg_auto_cts = 0, cts = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic txd, txrdy, tx_empty_irq, ovf_flag;
  int nchk = 0, nfail = 0;
  longint cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    repeat (3) @(negedge clk);
    tick16 = 1;
    @(negedge clk);
    tick16 = 0;
  end

  sertx_fc i_sertx_fc (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic recv(input int nb, input bit pe, output logic [7:0] d,
                      output logic pb, output logic sb, output logic st, output longint t0);
    while (txd !== 1'b0) @(negedge clk);
    t0 = cyc;
    repeat (32) @(negedge clk);
    st = txd;
    d = 0; pb = 0;
    for (int i = 0; i < nb; i++) begin
      repeat (64) @(negedge clk);
      d[i] = txd;
    end
    if (pe) begin
      repeat (64) @(negedge clk);
      pb = txd;
    end
    repeat (64) @(negedge clk);
    sb = txd;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d, e, m;
    logic pb, sb, stb;
    longint ta, tb2;
    bit hold;

    repeat (2) @(negedge clk);
    chk(txd === 1 && txrdy === 1, "R1 reset line/txrdy", {txd, txrdy}, 2'b11);
    rst_n = 1;
    @(negedge clk);
    chk(tx_empty_irq === 1 && ovf_flag === 0, "R1 empty/ovf", {tx_empty_irq, ovf_flag}, 2'b10);

    // sweep: cts low with auto flow off must not block (R9)
    for (int lc = 0; lc < 4; lc++)
      for (int pm = 0; pm < 3; pm++)
        for (int sc = 0; sc < 3; sc++) begin
          int nb, pe, stk;
          logic [7:0] v1, v2;
          nb = lc + 5; pe = (pm != 0) ? 1 : 0;
          stk = (sc == 0) ? 16 : (sc == 1) ? 24 : 32;
          cfg_len = 2'(lc); cfg_par_en = pm != 0; cfg_par_odd = pm == 2;
          cfg_stop = (sc == 2) ? 2'b10 : 2'(sc);
          m = 8'hFF >> (3 - lc);
          v1 = 8'((lc * 37 + pm * 11 + sc * 53 + 5) ^ 8'hE0);
          v2 = ~v1;
          wr(v1); wr(v2);
          recv(nb, pe, d, pb, sb, stb, ta);
          chk(stb === 0, "R2 start bit", stb, 0);
          chk(d === (v1 & m), "R2 data bits", d, v1 & m);
          if (pe) chk(pb === (^(v1 & m) ^ (pm == 2)), "R3 parity", pb, ^(v1 & m) ^ (pm == 2));
          chk(sb === 1, "R4 stop level", sb, 1);
          recv(nb, pe, d, pb, sb, stb, tb2);
          chk(d === (v2 & m), "R9 data sent with cts low, auto off", d, v2 & m);
          if (pe) chk(pb === (^(v2 & m) ^ (pm == 2)), "R3 parity 2", pb, ^(v2 & m) ^ (pm == 2));
          chk(tb2 - ta == 4 * (16 * (1 + nb + pe) + stk), "R4 R5 frame length",
              tb2 - ta, 4 * (16 * (1 + nb + pe) + stk));
          while (tx_empty_irq !== 1) @(negedge clk);
        end

    // queue fill, order, overflow
    do_reset();
    cfg_len = 3; cfg_par_en = 0; cfg_stop = 0; cfg_fifo_en = 1; cfg_auto_cts = 1; cts = 0;
    for (int i = 0; i < 15; i++) wr(8'(8'hA0 + i));
    chk(txrdy === 1, "R6 txrdy with 15 held", txrdy, 1);
    wr(8'hAF);
    chk(txrdy === 0, "R6 txrdy with 16 held", txrdy, 0);
    chk(ovf_flag === 0, "R8 no ovf yet", ovf_flag, 0);
    wr(8'h55);
    chk(ovf_flag === 1, "R8 ovf set", ovf_flag, 1);
    hold = 1;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (txd !== 1) hold = 0; end
    chk(hold, "R9 no start while cts low", hold, 1);
    cts = 1;
    for (int i = 0; i < 16; i++) begin
      recv(8, 0, d, pb, sb, stb, ta);
      chk(d === 8'(8'hA0 + i), "R6 order", d, 8'hA0 + i);
    end
    repeat (300) @(negedge clk);
    chk(tx_empty_irq === 1 && txd === 1, "R8 dropped byte not sent", {tx_empty_irq, txd}, 2'b11);
    chk(ovf_flag === 1, "R8 ovf sticky", ovf_flag, 1);

    // single holding register
    do_reset();
    cfg_fifo_en = 0; cfg_auto_cts = 1; cts = 0;
    wr(8'h3C);
    chk(txrdy === 0, "R7 holding full", txrdy, 0);
    wr(8'h99);
    chk(ovf_flag === 1, "R7 R8 second write dropped", ovf_flag, 1);
    cts = 1;
    repeat (12) @(negedge clk);
    chk(txrdy === 1, "R7 holding freed on load", txrdy, 1);
    recv(8, 0, d, pb, sb, stb, ta);
    chk(d === 8'h3C, "R7 held byte", d, 8'h3C);
    repeat (400) @(negedge clk);
    chk(tx_empty_irq === 1, "R7 only one frame", tx_empty_irq, 1);

    // cts drop mid frame
    do_reset();
    cfg_fifo_en = 1; cfg_auto_cts = 1; cts = 1;
    wr(8'h0F); wr(8'hF0);
    fork
      recv(8, 0, d, pb, sb, stb, ta);
      begin
        while (txd !== 1'b0) @(negedge clk);
        repeat (200) @(negedge clk);
        cts = 0;
      end
    join
    chk(d === 8'h0F && sb === 1, "R10 frame completes", {d, sb}, {8'h0F, 1'b1});
    hold = 1;
    for (int i = 0; i < 600; i++) begin @(negedge clk); if (txd !== 1) hold = 0; end
    chk(hold, "R10 pause before next start", hold, 1);
    chk(tx_empty_irq === 0, "R12 not empty with queued byte", tx_empty_irq, 0);
    cts = 1;
    recv(8, 0, d, pb, sb, stb, ta);
    chk(d === 8'hF0, "R10 resumes", d, 8'hF0);
    chk(tx_empty_irq === 0, "R12 not empty during stop", tx_empty_irq, 0);
    repeat (64) @(negedge clk);
    chk(tx_empty_irq === 1, "R12 empty after stop", tx_empty_irq, 1);

    // break
    cfg_break = 1;
    @(negedge clk);
    chk(txd === 0, "R11 break low", txd, 0);
    repeat (100) @(negedge clk);
    chk(txd === 0, "R11 break held", txd, 0);
    cfg_break = 0;
    @(negedge clk);
    chk(txd === 1, "R11 break released", txd, 1);

    finish_run();
  end
endmodule